// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block keeps dynamic memory contents alive by making sure every row of every bank is refreshed within one retention period. It counts clock cycles and raises refresh commands that carry a row and bank address. The memory controller answers each command with a one-cycle done pulse. The same block also arbitrates a single access port against refresh. A requester raises an access request and holds it for as long as it needs the array. No access is granted while a row refresh is outstanding.

A mode input chooses between two policies. In spread mode, one row refresh is due every `PERIOD_CYCLES / (NUM_ROWS*NUM_BANKS)` cycles. In block mode, every row is refreshed in one back-to-back run once per period. A sticky flag records any refresh deadline that was missed.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `acc_gnt`, `ref_req` and `deadline_miss` are 0 and the refresh address is row 0 of bank 0. A request held during reset is not granted.
- R2: With `mode_block`=0 and every command answered at once, successive rising edges of `ref_req` are exactly `PERIOD_CYCLES/(NUM_ROWS*NUM_BANKS)` cycles apart, with one row per command.
- R3: With `mode_block`=1, `NUM_ROWS*NUM_BANKS` refresh commands are issued once per `PERIOD_CYCLES`. `ref_req` stays high across the whole run, and the next address is presented in the cycle after each `ref_done`.
- R4: Each accepted `ref_done` advances the row by one. After row `NUM_ROWS-1` the row returns to 0 and the bank advances by one. After the last row of bank `NUM_BANKS-1` the address wraps to row 0, bank 0. The address is otherwise stable.
- R5: `acc_gnt` and `ref_req` are never high in the same cycle.
- R6: With no refresh owed, a request raised while idle is granted one cycle later. The grant stays high as long as `acc_req` stays high, even when a refresh falls due. The owed refresh starts only after the request drops.
- R7: When a refresh is owed and a new request is waiting in the same idle cycle, the refresh is issued first. The request is granted only after the refresh completes.
- R8: `deadline_miss` rises if a refresh is still owed at the moment the next one falls due, and it stays high until reset.
- R9: A `ref_done` pulse while `ref_req` is low has no effect on the refresh address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_block | input | 1 | 0 = spread refresh, 1 = all rows in one run per period |
| acc_req | input | 1 | Access request, held for the length of the access |
| acc_gnt | output | 1 | Access granted, high while the access may proceed |
| ref_req | output | 1 | Refresh command for the row shown on the address outputs |
| ref_row | output | ROW_W | Row address of the refresh command |
| ref_bank | output | BANK_W | Bank address of the refresh command |
| ref_done | input | 1 | One-cycle acknowledge that the commanded row is refreshed |
| deadline_miss | output | 1 | Sticky flag: a refresh was still owed when the next fell due |

## Verification
The bench measures the spacing between spread-mode commands: a timer off by one cycle would drift that spacing away from the expected interval. It also counts a whole block-mode run, and an off-by-one debt counter would show up there as one command too few or too many. It follows the address through row and bank wrap, where a missing carry would repeat bank 0. It holds an access across a due refresh and then re-requests at once: a design that preempted, or that let the waiting request win, would show a grant and a refresh together, or a grant ahead of the refresh. Stray acknowledges while idle and an unanswered command check that the address does not move and that the miss flag latches and holds.

// File: rtl/drs_pkg.sv
package drs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_REFRESH = 2'd2
    } drs_state_e;
endpackage

// File: rtl/drs_tick_gen.sv
// Cycle counter that marks when the next refresh falls due.
module drs_tick_gen #(
    parameter int PERIOD_CYCLES = 64000,
    parameter int INTERVAL      = 250,
    parameter int CNT_W         = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic block_mode,
    output logic due
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_st_t;

    tick_st_t         st_d, st_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        st_d  = st_q;
        limit = block_mode ? CNT_W'(PERIOD_CYCLES - 1) : CNT_W'(INTERVAL - 1);
        due   = (st_q.cnt >= limit);
        st_d.cnt = due ? '0 : st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/drs_addr_walk.sv
// Row/bank pointer: row is the fast digit, bank the slow one.
module drs_addr_walk #(
    parameter int NUM_ROWS  = 64,
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 6,
    parameter int BANK_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ROW_W-1:0]  row,
    output logic [BANK_W-1:0] bank
);
    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [BANK_W-1:0] bank;
    } walk_st_t;

    walk_st_t st_d, st_q;
    logic     row_last, bank_last;

    always_comb begin
        st_d      = st_q;
        row_last  = (st_q.row == ROW_W'(NUM_ROWS - 1));
        bank_last = (st_q.bank == BANK_W'(NUM_BANKS - 1));
        if (step) begin
            if (row_last) begin
                st_d.row  = '0;
                st_d.bank = bank_last ? '0 : st_q.bank + BANK_W'(1);
            end else begin
                st_d.row  = st_q.row + ROW_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row  = st_q.row;
    assign bank = st_q.bank;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int PERIOD_CYCLES = 64000,
    parameter int NUM_ROWS      = 64,
    parameter int NUM_BANKS     = 4,
    localparam int ROW_W  = (NUM_ROWS  > 1) ? $clog2(NUM_ROWS)  : 1,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_block,
    input  logic              acc_req,
    output logic              acc_gnt,
    output logic              ref_req,
    output logic [ROW_W-1:0]  ref_row,
    output logic [BANK_W-1:0] ref_bank,
    input  logic              ref_done,
    output logic              deadline_miss
);
    import drs_pkg::*;

    localparam int TOTAL_ROWS = NUM_ROWS * NUM_BANKS;
    localparam int RAW_INTV   = PERIOD_CYCLES / TOTAL_ROWS;
    localparam int INTERVAL   = (RAW_INTV > 0) ? RAW_INTV : 1;
    localparam int CNT_W      = $clog2(PERIOD_CYCLES + 1);
    localparam int OWE_W      = $clog2(TOTAL_ROWS + 1);

    typedef struct packed {
        drs_state_e       state;
        logic [OWE_W-1:0] owe;
        logic             miss;
    } sched_st_t;

    sched_st_t        st_d, st_q;
    logic             due;
    logic             retire;
    logic [OWE_W-1:0] owe_left;

    drs_tick_gen #(
        .PERIOD_CYCLES(PERIOD_CYCLES),
        .INTERVAL     (INTERVAL),
        .CNT_W        (CNT_W)
    ) tick_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .block_mode(mode_block),
        .due       (due)
    );

    drs_addr_walk #(
        .NUM_ROWS (NUM_ROWS),
        .NUM_BANKS(NUM_BANKS),
        .ROW_W    (ROW_W),
        .BANK_W   (BANK_W)
    ) walk_i (
        .clk  (clk),
        .rst_n(rst_n),
        .step (retire),
        .row  (ref_row),
        .bank (ref_bank)
    );

    always_comb begin
        st_d     = st_q;
        retire   = (st_q.state == ST_REFRESH) && ref_done;
        owe_left = st_q.owe - (retire ? OWE_W'(1) : OWE_W'(0));
        st_d.owe = owe_left;

        if (due) begin
            if (owe_left != '0) st_d.miss = 1'b1;
            if (mode_block)                       st_d.owe = OWE_W'(TOTAL_ROWS);
            else if (owe_left < OWE_W'(TOTAL_ROWS)) st_d.owe = owe_left + OWE_W'(1);
        end

        unique case (st_q.state)
            ST_IDLE: begin
                if (st_q.owe != '0)  st_d.state = ST_REFRESH;
                else if (acc_req)    st_d.state = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (!acc_req)        st_d.state = ST_IDLE;
            end
            ST_REFRESH: begin
                if (ref_done)
                    st_d.state = (st_d.owe != '0) ? ST_REFRESH : ST_IDLE;
            end
            default:                 st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= ST_IDLE;
            st_q.owe   <= '0;
            st_q.miss  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_gnt       = (st_q.state == ST_ACCESS);
    assign ref_req       = (st_q.state == ST_REFRESH);
    assign deadline_miss = st_q.miss;
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
    parameter int ROW_W  = 6,
    parameter int BANK_W = 2,
    parameter int TOTAL  = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_req,
    input logic              acc_gnt,
    input logic              ref_req,
    input logic              ref_done,
    input logic [ROW_W-1:0]  ref_row,
    input logic [BANK_W-1:0] ref_bank,
    input logic              deadline_miss
);
    // R5: refresh and access exclusive
    assert_mutex_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_gnt && ref_req));

    // R6: an access is not taken away while it is still requested
    assert_grant_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_gnt && acc_req) |=> acc_gnt);

    // R3: a command stays up until acknowledged
    assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_done) |=> ref_req);

    // R4, R9: the address moves only on an acknowledged command
    assert_addr_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_req && ref_done) |=> ($stable(ref_row) && $stable(ref_bank)));

    assert_addr_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (TOTAL > 1 && ref_req && ref_done) |=> !($stable(ref_row) && $stable(ref_bank)));

    // R8: miss flag is sticky
    assert_miss_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        deadline_miss |=> deadline_miss);
endmodule

bind dram_refresh_sched drs_checker #(
    .ROW_W (ROW_W),
    .BANK_W(BANK_W),
    .TOTAL (TOTAL_ROWS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_req      (acc_req),
    .acc_gnt      (acc_gnt),
    .ref_req      (ref_req),
    .ref_done     (ref_done),
    .ref_row      (ref_row),
    .ref_bank     (ref_bank),
    .deadline_miss(deadline_miss)
);

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P_CYC      = 512;
    localparam int N_ROWS     = 8;
    localparam int N_BANKS    = 2;
    localparam int TOTAL      = N_ROWS * N_BANKS;
    localparam int INTV       = P_CYC / TOTAL;
    localparam int WDOG_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_block = 1'b0;
    logic       acc_req = 1'b0;
    logic       ref_done = 1'b0;
    logic       acc_gnt, ref_req, deadline_miss;
    logic [2:0] ref_row;
    logic [0:0] ref_bank;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_row = 0;
    int exp_bank = 0;
    int mutex_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_refresh_sched #(
        .PERIOD_CYCLES(P_CYC),
        .NUM_ROWS     (N_ROWS),
        .NUM_BANKS    (N_BANKS)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_block   (mode_block),
        .acc_req      (acc_req),
        .acc_gnt      (acc_gnt),
        .ref_req      (ref_req),
        .ref_row      (ref_row),
        .ref_bank     (ref_bank),
        .ref_done     (ref_done),
        .deadline_miss(deadline_miss)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
    endtask

    function automatic void exp_advance();
        if (exp_row == N_ROWS - 1) begin
            exp_row  = 0;
            exp_bank = (exp_bank == N_BANKS - 1) ? 0 : exp_bank + 1;
        end else begin
            exp_row = exp_row + 1;
        end
    endfunction

    task automatic check_addr(input string tag);
        check_eq({tag, " row"},  int'(ref_row),  exp_row);
        check_eq({tag, " bank"}, int'(ref_bank), exp_bank);
    endtask

    task automatic do_reset(input logic blk);
        rst_n = 1'b0;
        ref_done = 1'b0;
        mode_block = blk;
        repeat (3) step();
        rst_n = 1'b1;
        exp_row = 0;
        exp_bank = 0;
    endtask

    task automatic wait_cmd(input int limit, input string tag);
        int n = 0;
        while (!ref_req && n < limit) begin
            step();
            n++;
        end
        if (!ref_req) check_eq({tag, " command timeout"}, 0, 1);
    endtask

    always @(negedge clk) begin
        if (rst_n && acc_gnt && ref_req) begin
            mutex_bad++;
            $display("FAIL R5 grant and refresh together actual 1 expected 0");
        end
    end

    always @(negedge clk) begin
        if (cyc > WDOG_LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected below %0d", cyc, WDOG_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int last_rise;
        int rises;
        logic prev_req;
        int wait_ctr;
        int hold;
        int n;
        void'($urandom(32'd5150));

        // R1: reset state, request held through reset
        acc_req = 1'b1;
        step();
        check_eq("R1 grant in reset", int'(acc_gnt), 0);
        check_eq("R1 req in reset", int'(ref_req), 0);
        check_eq("R1 miss in reset", int'(deadline_miss), 0);
        check_eq("R1 row in reset", int'(ref_row), 0);
        check_eq("R1 bank in reset", int'(ref_bank), 0);
        do_reset(1'b0);
        acc_req = 1'b0;
        check_eq("R1 grant after release", int'(acc_gnt), 0);
        check_eq("R1 req after release", int'(ref_req), 0);

        // R2: spacing in spread mode with instant answers
        rises = 0;
        last_rise = 0;
        prev_req = 1'b0;
        n = 0;
        while (rises < 5 && n < 6 * INTV) begin
            step();
            n++;
            ref_done = 1'b0;
            if (ref_req && !prev_req) begin
                if (rises > 0) check_eq("R2 interval", cyc - last_rise, INTV);
                last_rise = cyc;
                rises++;
                check_addr("R4 spread");
                exp_advance();
                ref_done = 1'b1;
            end
            prev_req = ref_req;
        end
        step();
        ref_done = 1'b0;
        check_eq("R2 rise count", rises, 5);

        // R9: stray acknowledges while idle
        step();
        check_eq("R9 idle before stray", int'(ref_req), 0);
        ref_done = 1'b1;
        repeat (3) step();
        ref_done = 1'b0;
        check_eq("R9 row after stray", int'(ref_row), exp_row);
        check_eq("R9 bank after stray", int'(ref_bank), exp_bank);
        wait_cmd(2 * INTV, "R9");
        check_addr("R9 next command");
        exp_advance();
        ref_done = 1'b1;
        step();
        ref_done = 1'b0;

        // R6: grant one cycle after request, held across a due refresh
        step();
        acc_req = 1'b1;
        step();
        check_eq("R6 grant latency", int'(acc_gnt), 1);
        n = 0;
        repeat (INTV) begin
            step();
            if (!acc_gnt) n++;
            if (ref_req) n++;
        end
        check_eq("R6 grant held, refresh deferred", n, 0);

        // R7: release then re-request at once; refresh must win
        acc_req = 1'b0;
        step();
        acc_req = 1'b1;
        step();
        check_eq("R7 refresh first", int'(ref_req), 1);
        check_eq("R7 grant waits", int'(acc_gnt), 0);
        check_addr("R7 address");
        exp_advance();
        ref_done = 1'b1;
        step();
        ref_done = 1'b0;
        step();
        check_eq("R7 grant after refresh", int'(acc_gnt), 1);
        acc_req = 1'b0;
        step();

        // Random mix: accesses and delayed acknowledges
        wait_ctr = $urandom % 4;
        hold = 0;
        repeat (3000) begin
            step();
            ref_done = 1'b0;
            if (ref_req) begin
                if (wait_ctr == 0) begin
                    check_addr("R4 random");
                    exp_advance();
                    ref_done = 1'b1;
                    wait_ctr = $urandom % 4;
                end else begin
                    wait_ctr--;
                end
            end
            if (!acc_req) begin
                if ($urandom % 4 == 0) begin
                    acc_req = 1'b1;
                    hold = 1 + ($urandom % 8);
                end
            end else if (acc_gnt) begin
                if (hold == 0) acc_req = 1'b0;
                else hold--;
            end
        end
        acc_req = 1'b0;
        ref_done = 1'b0;
        check_eq("R8 no miss under light load", int'(deadline_miss), 0);

        // R3: block mode run, access blocked throughout
        do_reset(1'b1);
        wait_cmd(P_CYC + 8, "R3");
        acc_req = 1'b1;
        n = 0;
        hold = 0;
        while (ref_req && n < TOTAL + 4) begin
            check_addr("R4 block");
            if (acc_gnt) hold++;
            exp_advance();
            ref_done = 1'b1;
            n++;
            step();
        end
        ref_done = 1'b0;
        check_eq("R3 rows per run", n, TOTAL);
        check_eq("R3 grant blocked during run", hold, 0);
        check_eq("R4 wrap row", int'(ref_row), 0);
        check_eq("R4 wrap bank", int'(ref_bank), 0);
        step();
        check_eq("R6 grant after run", int'(acc_gnt), 1);
        acc_req = 1'b0;

        // R8: unanswered command latches the miss flag
        do_reset(1'b0);
        wait_cmd(2 * INTV, "R8");
        check_eq("R8 no miss yet", int'(deadline_miss), 0);
        repeat (INTV + 2) step();
        check_eq("R8 miss raised", int'(deadline_miss), 1);
        check_addr("R8 held address");
        exp_advance();
        ref_done = 1'b1;
        step();
        ref_done = 1'b0;
        repeat (4) step();
        check_eq("R8 miss sticky", int'(deadline_miss), 1);

        check_eq("R5 exclusive", mutex_bad, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule